// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads page-table entries from memory through a plain request/response port. A requester presents an address and an access kind (read, write or execute) while `req_ready` is high. The walker first compares the first-level index against a table-length bound. It then reads the first-level entry at the root base, follows it to a second-level table and reads the leaf entry there. After the leaf read it issues a single pulse on `rsp_valid` that carries either the translated address or a fault code.

Both levels check the valid bit. Only the leaf entry is checked for permissions. A write that is permitted to a page whose dirty bit is still clear makes the walker store the leaf entry back with the dirty bit set before it answers. The walker serves one request at a time. The memory side carries one outstanding access, and every access is acknowledged by a one-cycle `mem_rvalid`.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: The virtual address splits into the first-level index in bits 31:22, the second-level index in bits 21:12 and the page offset in bits 11:0. The first read goes to `root_base + 4*index1`. The second read goes to `{frame of level-1 entry, 12'b0} + 4*index2`. Each memory request lasts exactly one cycle.
- R3: Entry layout: bit 0 valid, bit 1 read-allowed, bit 2 write-allowed, bit 3 execute-allowed, bit 4 dirty, bits 31:12 frame number. A successful walk answers with fault code 0 and `rsp_paddr = {leaf frame, vaddr[11:0]}`.
- R4: When index1 is greater than or equal to `tbl_len`, the answer is fault code 1 (out of bounds) and no memory access is made.
- R5: A clear valid bit in either entry gives fault code 2. When the first-level entry is invalid, no second read is made.
- R6: Access codes are 0 read, 1 write and 2 execute. Each needs bit 1, 2 or 3 of the leaf entry respectively. A missing permission, or access code 3, gives fault code 3 (protection).
- R7: A permitted write whose leaf entry has bit 4 clear causes exactly one memory write of that entry with bit 4 set, to the leaf's address, before the response. Any other walk writes nothing.
- R8: `req_ready` is low from the cycle after acceptance until the response cycle ends. `rsp_valid` is a one-cycle pulse.
- R9: Every faulting response carries `rsp_paddr` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Byte address of the first-level table |
| tbl_len | input | 11 | Number of usable first-level entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 2 | 0 none, 1 bound, 2 invalid, 3 protection |
| rsp_paddr | output | 32 | Translated address, 0 on fault |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rvalid | input | 1 | Read data valid, or write acknowledged |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The bench drives addresses into a table set up so that each leaf has its own permission and dirty pattern. This shows that read, write and execute are checked against three separate bits, and that an invalid entry at level one differs from one at level two in how many reads it causes. The same write is repeated on a page whose dirty bit starts clear: the first write must produce a memory write and the second must not. Indices on both sides of a lowered length bound, and a moved root, show that the bound check and the entry-address arithmetic are separate from the permission logic.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [1:0] {
      ACC_RD = 2'd0,
      ACC_WR = 2'd1,
      ACC_EX = 2'd2,
      ACC_XX = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_BOUND = 2'd1,
      FLT_INVAL = 2'd2,
      FLT_PROT  = 2'd3
   } fault_e;

   localparam int PTE_V = 0;
   localparam int PTE_R = 1;
   localparam int PTE_W = 2;
   localparam int PTE_X = 3;
   localparam int PTE_D = 4;
   localparam int N_ACC = 3;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int L1_BITS   = 10,
   parameter int L2_BITS   = 10,
   parameter int OFF_BITS  = 12,
   parameter int PTE_BYTES = 4
) (
   input  logic [VA_W-1:0]    vaddr,
   input  logic [PA_W-1:0]    root,
   input  logic [PA_W-1:0]    tbase,
   output logic [L1_BITS-1:0] idx1,
   output logic [PA_W-1:0]    addr1,
   output logic [PA_W-1:0]    addr2
);
   localparam int SHIFT = $clog2(PTE_BYTES);
   localparam int L2_LO = OFF_BITS;
   localparam int L1_LO = OFF_BITS + L2_BITS;

   logic [L2_BITS-1:0] idx2;
   logic [PA_W-1:0]    off1, off2;

   assign idx1 = vaddr[L1_LO +: L1_BITS];
   assign idx2 = vaddr[L2_LO +: L2_BITS];

   assign off1  = PA_W'(idx1) << SHIFT;
   assign off2  = PA_W'(idx2) << SHIFT;
   assign addr1 = root + off1;
   assign addr2 = tbase + off2;
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
   import ptw_pkg::*;
#(
   parameter int PTE_BITS = 32
) (
   input  logic [PTE_BITS-1:0] pte,
   input  logic [1:0]          acc,
   output logic [1:0]          fault,
   output logic                need_wb
);
   logic [N_ACC-1:0] perm;
   logic             allowed;

   for (genvar k = 0; k < N_ACC; k++) begin : g_perm
      assign perm[k] = pte[PTE_R + k];
   end

   always_comb begin
      allowed = 1'b0;
      for (int k = 0; k < N_ACC; k++) begin
         if (acc == 2'(k)) allowed = perm[k];
      end
   end

   always_comb begin
      if (!pte[PTE_V])   fault = FLT_INVAL;
      else if (!allowed) fault = FLT_PROT;
      else               fault = FLT_NONE;
   end

   assign need_wb = (fault == FLT_NONE) && (acc == ACC_WR) && !pte[PTE_D];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int L1_BITS   = 10,
   parameter int L2_BITS   = 10,
   parameter int OFF_BITS  = 12,
   parameter int PTE_BYTES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PA_W-1:0]     root_base,
   input  logic [L1_BITS:0]    tbl_len,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [VA_W-1:0]     req_vaddr,
   input  logic [1:0]          req_acc,
   output logic                rsp_valid,
   output logic [1:0]          rsp_fault,
   output logic [PA_W-1:0]     rsp_paddr,
   output logic                mem_req,
   output logic                mem_we,
   output logic [PA_W-1:0]     mem_addr,
   output logic [PTE_BYTES*8-1:0] mem_wdata,
   input  logic                mem_rvalid,
   input  logic [PTE_BYTES*8-1:0] mem_rdata
);
   localparam int PTE_BITS = PTE_BYTES * 8;
   localparam int FRAME_W  = PA_W - OFF_BITS;

   initial begin
      if (VA_W != L1_BITS + L2_BITS + OFF_BITS)
         $fatal(1, "ptw_walker: index and offset widths must cover VA_W");
      if (PA_W > PTE_BITS)
         $fatal(1, "ptw_walker: PA_W exceeds entry width");
      if ((PTE_BYTES & (PTE_BYTES - 1)) != 0)
         $fatal(1, "ptw_walker: PTE_BYTES must be a power of two");
   end

   typedef enum logic [2:0] {
      S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ,
      S_L2_WAIT, S_WB_REQ, S_WB_WAIT, S_RESP
   } st_e;

   st_e                 st_q;
   logic [VA_W-1:0]     va_q;
   logic [1:0]          acc_q;
   logic [PA_W-1:0]     root_q, tbase_q, pa_q;
   logic [PTE_BITS-1:0] leaf_q;
   logic [1:0]          flt_q;

   logic [L1_BITS-1:0]  idx1_new, idx1_unused;
   logic [PA_W-1:0]     addr1, addr2, a1_unused, a2_unused;
   logic [1:0]          leaf_flt;
   logic                leaf_wb;
   logic                accept;

   // Bound check on the incoming address, before any state is stored
   ptw_addr_gen #(
      .VA_W(VA_W), .PA_W(PA_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
      .OFF_BITS(OFF_BITS), .PTE_BYTES(PTE_BYTES)
   ) u_idx_in (
      .vaddr(req_vaddr), .root(root_base), .tbase(root_base),
      .idx1(idx1_new), .addr1(a1_unused), .addr2(a2_unused)
   );

   // Entry addresses for the walk in progress
   ptw_addr_gen #(
      .VA_W(VA_W), .PA_W(PA_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
      .OFF_BITS(OFF_BITS), .PTE_BYTES(PTE_BYTES)
   ) u_idx_walk (
      .vaddr(va_q), .root(root_q), .tbase(tbase_q),
      .idx1(idx1_unused), .addr1(addr1), .addr2(addr2)
   );

   ptw_leaf_check #(.PTE_BITS(PTE_BITS)) u_leaf (
      .pte(mem_rdata), .acc(acc_q), .fault(leaf_flt), .need_wb(leaf_wb)
   );

   assign req_ready = (st_q == S_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         va_q    <= '0;
         acc_q   <= '0;
         root_q  <= '0;
         tbase_q <= '0;
         leaf_q  <= '0;
         pa_q    <= '0;
         flt_q   <= FLT_NONE;
      end else begin
         case (st_q)
            S_IDLE: if (accept) begin
               va_q   <= req_vaddr;
               acc_q  <= req_acc;
               root_q <= root_base;
               pa_q   <= '0;
               if ({1'b0, idx1_new} >= tbl_len) begin
                  flt_q <= FLT_BOUND;
                  st_q  <= S_RESP;
               end else begin
                  flt_q <= FLT_NONE;
                  st_q  <= S_L1_REQ;
               end
            end
            S_L1_REQ:  st_q <= S_L1_WAIT;
            S_L1_WAIT: if (mem_rvalid) begin
               if (!mem_rdata[PTE_V]) begin
                  flt_q <= FLT_INVAL;
                  st_q  <= S_RESP;
               end else begin
                  tbase_q <= {mem_rdata[OFF_BITS +: FRAME_W], {OFF_BITS{1'b0}}};
                  st_q    <= S_L2_REQ;
               end
            end
            S_L2_REQ:  st_q <= S_L2_WAIT;
            S_L2_WAIT: if (mem_rvalid) begin
               flt_q  <= leaf_flt;
               leaf_q <= mem_rdata;
               if (leaf_flt == FLT_NONE)
                  pa_q <= {mem_rdata[OFF_BITS +: FRAME_W], va_q[OFF_BITS-1:0]};
               st_q <= leaf_wb ? S_WB_REQ : S_RESP;
            end
            S_WB_REQ:  st_q <= S_WB_WAIT;
            S_WB_WAIT: if (mem_rvalid) st_q <= S_RESP;
            S_RESP:    st_q <= S_IDLE;
            default:   st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req = 1'b0;
      mem_we  = 1'b0;
      mem_addr = addr1;
      case (st_q)
         S_L1_REQ: mem_req = 1'b1;
         S_L2_REQ: begin mem_req = 1'b1; mem_addr = addr2; end
         S_WB_REQ: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = addr2; end
         S_L2_WAIT, S_WB_WAIT: mem_addr = addr2;
         default: ;
      endcase
   end

   assign mem_wdata = leaf_q | (PTE_BITS'(1) << PTE_D);
   assign rsp_valid = (st_q == S_RESP);
   assign rsp_fault = flt_q;
   assign rsp_paddr = pa_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
   import ptw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int L1_BITS   = 10,
   parameter int L2_BITS   = 10,
   parameter int OFF_BITS  = 12,
   parameter int PTE_BYTES = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [L1_BITS:0]      tbl_len,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic [VA_W-1:0]       req_vaddr,
   input logic                  rsp_valid,
   input logic [1:0]            rsp_fault,
   input logic [PA_W-1:0]       rsp_paddr,
   input logic                  mem_req,
   input logic                  mem_we,
   input logic [PTE_BYTES*8-1:0] mem_wdata
);
   localparam int L1_LO = OFF_BITS + L2_BITS;

   logic busy, pend_oob;
   logic [L1_BITS:0] idx_in;

   assign idx_in = {1'b0, req_vaddr[L1_LO +: L1_BITS]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         pend_oob <= 1'b0;
      end else if (req_valid && req_ready) begin
         busy     <= 1'b1;
         pend_oob <= (idx_in >= tbl_len);
      end else if (rsp_valid) begin
         busy     <= 1'b0;
         pend_oob <= 1'b0;
      end
   end

   assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);
   assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_mem_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   assert_no_access_oob_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_oob |-> !mem_req);
   assert_oob_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && pend_oob) |-> (rsp_fault == FLT_BOUND));
   assert_wb_sets_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[PTE_D] && mem_wdata[PTE_V] && mem_wdata[PTE_W]));
   assert_fault_zero_pa_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));
endmodule

bind ptw_walker ptw_walker_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
   .OFF_BITS(OFF_BITS), .PTE_BYTES(PTE_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tbl_len(tbl_len), .req_valid(req_valid),
   .req_ready(req_ready), .req_vaddr(req_vaddr), .rsp_valid(rsp_valid),
   .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .mem_req(mem_req),
   .mem_we(mem_we), .mem_wdata(mem_wdata)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] root_base = '0;
   logic [10:0] tbl_len = 11'd8;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        req_ready, rsp_valid, mem_req, mem_we;
   logic [1:0]  rsp_fault;
   logic [31:0] rsp_paddr, mem_addr, mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   ptw_walker u_dut (
      .clk(clk), .rst_n(rst_n), .root_base(root_base), .tbl_len(tbl_len),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata)
   );

   // Bench memory: 8 KB, answers one cycle after each request
   logic [31:0] mem [2048];
   int          n_rd, n_wr;
   logic [31:0] rd_log [4];
   logic [31:0] wr_addr;

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
         mem_rvalid <= 1'b1;
         if (mem_we) begin
            mem[mem_addr[12:2]] <= mem_wdata;
            wr_addr <= mem_addr;
            n_wr <= n_wr + 1;
         end else begin
            mem_rdata <= mem[mem_addr[12:2]];
            if (n_rd < 4) rd_log[n_rd] <= mem_addr;
            n_rd <= n_rd + 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string flt_tag(input logic [1:0] f);
      case (f)
         2'd0: return "R3";
         2'd1: return "R4";
         2'd2: return "R5";
         default: return "R6";
      endcase
   endfunction

   logic [1:0]  got_f;
   logic [31:0] got_pa;

   task automatic walk(input logic [31:0] va, input logic [1:0] acc);
      int t;
      @(negedge clk);
      n_rd = 0; n_wr = 0;
      req_vaddr = va; req_acc = acc; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 ready low after accept", {31'b0, req_ready}, 32'd0);
      t = 0;
      while (!rsp_valid && t < 40) begin
         @(negedge clk);
         t++;
      end
      chk("R8 response arrives", {31'b0, rsp_valid}, 32'd1);
      got_f = rsp_fault;
      got_pa = rsp_paddr;
      @(negedge clk);
      chk("R8 single pulse and ready again", {30'b0, rsp_valid, req_ready}, 32'd1);
   endtask

   typedef struct packed {
      logic [31:0] va;
      logic [1:0]  acc;
      logic [1:0]  flt;
      logic [31:0] pa;
      logic [2:0]  nrd;
      logic        nwr;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0123, 2'd0, 2'd0, 32'hABCD_E123, 3'd2, 1'b0},
      '{32'h0000_0FFF, 2'd2, 2'd3, 32'h0,         3'd2, 1'b0},
      '{32'h0000_1456, 2'd1, 2'd0, 32'h1234_5456, 3'd2, 1'b1},
      '{32'h0000_1456, 2'd1, 2'd0, 32'h1234_5456, 3'd2, 1'b0},
      '{32'h0000_2010, 2'd2, 2'd0, 32'h5555_5010, 3'd2, 1'b0},
      '{32'h0000_2010, 2'd0, 2'd3, 32'h0,         3'd2, 1'b0},
      '{32'h0000_3000, 2'd0, 2'd2, 32'h0,         3'd2, 1'b0},
      '{32'h0040_0000, 2'd0, 2'd2, 32'h0,         3'd1, 1'b0},
      '{32'h0080_4ABC, 2'd1, 2'd0, 32'h2222_2ABC, 3'd2, 1'b0},
      '{32'h0080_5777, 2'd2, 2'd0, 32'h3333_3777, 3'd2, 1'b0},
      '{32'h0200_0000, 2'd0, 2'd1, 32'h0,         3'd0, 1'b0},
      '{32'hFFC0_0000, 2'd1, 2'd1, 32'h0,         3'd0, 1'b0},
      '{32'h0000_0123, 2'd1, 2'd3, 32'h0,         3'd2, 1'b0},
      '{32'h0000_5001, 2'd3, 2'd3, 32'h0,         3'd2, 1'b0}
   };

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = '0;
      mem[0] = 32'h0000_1001;               // level 1, index 0 -> table at 0x1000
      mem[2] = 32'h0000_1001;               // level 1, index 2 -> same table
      mem[512] = 32'h0000_1001;             // level 1 at alternate root 0x800
      mem[1024 + 0] = 32'hABCD_E003;        // read only
      mem[1024 + 1] = 32'h1234_5007;        // read/write, clean
      mem[1024 + 2] = 32'h5555_5009;        // execute only
      mem[1024 + 3] = 32'h7777_7006;        // not valid
      mem[1024 + 4] = 32'h2222_2017;        // read/write, dirty
      mem[1024 + 5] = 32'h3333_300F;        // all permissions
      n_rd = 0; n_wr = 0;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset state", {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);

      for (int v = 0; v < NV; v++) begin
         walk(VECS[v].va, VECS[v].acc);
         chk({flt_tag(VECS[v].flt), " fault code"}, {30'b0, got_f}, {30'b0, VECS[v].flt});
         chk(VECS[v].flt == 2'd0 ? "R3 physical address" : "R9 zero address on fault",
             got_pa, VECS[v].pa);
         chk("R2 read count", n_rd, {29'b0, VECS[v].nrd});
         chk("R7 write count", n_wr, {31'b0, VECS[v].nwr});
         if (VECS[v].nrd >= 3'd1)
            chk("R2 level-1 entry address", rd_log[0], {20'b0, VECS[v].va[31:22], 2'b0});
         if (VECS[v].nrd == 3'd2)
            chk("R2 level-2 entry address", rd_log[1], 32'h1000 + {20'b0, VECS[v].va[21:12], 2'b0});
         if (VECS[v].nwr)
            chk("R7 write-back address", wr_addr, 32'h1000 + {20'b0, VECS[v].va[21:12], 2'b0});
      end

      chk("R7 stored entry has dirty set", mem[1025], 32'h1234_5017);

      // Length bound edge: last index inside, first index outside
      tbl_len = 11'd3;
      walk(32'h0080_0000, 2'd0);
      chk("R4 index below bound translates", {30'b0, got_f}, 32'd0);
      chk("R3 index below bound address", got_pa, 32'hABCD_E000);
      walk(32'h00C0_0000, 2'd0);
      chk("R4 index at bound faults", {30'b0, got_f}, 32'd1);
      chk("R4 no access at bound", n_rd + n_wr, 32'd0);

      // Moved root
      tbl_len = 11'd8;
      root_base = 32'h0000_0800;
      walk(32'h0000_5ABC, 2'd2);
      chk("R2 moved root address", rd_log[0], 32'h0000_0800);
      chk("R3 moved root translation", got_pa, 32'h3333_3ABC);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule